// File: doc/BRIEF.md
# Audio Power-Mode and Source Controller

This block settles the operating mode of a bus-powered audio device. From a host suspend request, a bus-attached indication, an active-low auxiliary-source input and a stream of frame-start events, it produces a low-power indicator, a mixer auxiliary-select control, a standalone-mode flag and a one-cycle start-of-frame strobe. It also steers front-panel key presses. While the device sits on the bus, the presses go to the USB report path. In standalone operation, volume and mute go straight to the audio core.

The device drops to low power when the host asks for it, when the bus goes away, or when no frame start has been seen for three frame periods while attached. A plugged-in auxiliary source overrides all three of these causes. The auxiliary input is synchronized and debounced before use. It selects the auxiliary mixer input, keeps the device in full power and also forces standalone control. The DAC path to the mixer is never switched off, so no output for it exists.

Top module: `pmc_audio_mode_ctrl`

## Requirements
- R1: With the auxiliary source inactive, a low level on `bus_attached` drives `suspend` high one clock later.
- R2: With the auxiliary source inactive, a high `host_suspend_req` drives `suspend` high one clock later. With attach present, frame starts arriving and no request, `suspend` is low.
- R3: `aux_present_n` is active low. A level held for DEBOUNCE_CYCLES clocks, after a two-flop synchronizer, sets `aux_select`. While `aux_select` is high, `suspend` stays low whatever the request or attach inputs do.
- R4: An excursion on `aux_present_n` shorter than DEBOUNCE_CYCLES clocks leaves `aux_select` unchanged.
- R5: A `frame_start` pulse while attached yields exactly one `sof_pulse` cycle, one clock later. While detached, `sof_pulse` stays low.
- R6: While attached, a gap with no `frame_start` of IDLE_MS*CYCLES_PER_MS clocks raises `suspend`. The next frame start clears it.
- R7: `standalone` is high when detached or when the auxiliary source is active. In standalone, key bits 0 (volume up), 1 (volume down) and 2 (mute) appear on `core_keys` one clock later, and `report_keys` stays zero.
- R8: In standalone, key bit 3 (bass-boost toggle) has no effect on either key output.
- R9: When not standalone, all four key bits appear at the same positions on `report_keys` one clock later, and `core_keys` stays zero.
- R10: During reset, `suspend`, `aux_select` and `sof_pulse` are low, and `standalone` equals the inverse of `bus_attached`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_attached | input | 1 | Device is connected to the bus |
| host_suspend_req | input | 1 | Host asks for low-power state |
| aux_present_n | input | 1 | Auxiliary analog source present, active low, asynchronous |
| frame_start | input | 1 | One-cycle pulse per received frame start |
| key_in | input | 4 | Key press pulses: bit0 vol up, bit1 vol down, bit2 mute, bit3 bass toggle |
| suspend | output | 1 | High in low-power mode |
| aux_select | output | 1 | Mixer includes the auxiliary input |
| standalone | output | 1 | Keys are served locally, not over the bus |
| sof_pulse | output | 1 | One-cycle start-of-frame strobe |
| report_keys | output | 4 | Key presses toward the host report path |
| core_keys | output | 3 | Volume up, volume down and mute toward the audio core |

## Verification
The hardest state to reach is the idle timeout, because it needs an attached bus, no auxiliary source, no host request and a frame-start gap longer than three frame periods. Any normal traffic keeps it from firing. The bench runs with a regular frame-start train, then stops it and samples just before and just after the limit. A single frame start then shows the recovery. The auxiliary veto is reached with held levels longer than the debounce, and the glitch case with an excursion of half that length.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef struct packed {
        logic bass;
        logic mute;
        logic vol_dn;
        logic vol_up;
    } key_t;

    typedef struct packed {
        logic mute;
        logic vol_dn;
        logic vol_up;
    } core_key_t;

    function automatic key_t report_route(input key_t k, input logic alone);
        return alone ? key_t'('0) : k;
    endfunction

    function automatic core_key_t core_route(input key_t k, input logic alone);
        core_key_t c;
        c.vol_up = k.vol_up & alone;
        c.vol_dn = k.vol_dn & alone;
        c.mute   = k.mute   & alone;
        return c;
    endfunction

    function automatic logic lowpower_cause(input logic host_req,
                                            input logic attached,
                                            input logic idle);
        return host_req | ~attached | idle;
    endfunction

endpackage

// File: rtl/pmc_sync_debounce.sv
module pmc_sync_debounce #(
    parameter int SYNC_STAGES     = 2,
    parameter int DEBOUNCE_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic level_async,
    output logic level_stable
);
    localparam int CW = (DEBOUNCE_CYCLES > 1) ? $clog2(DEBOUNCE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(DEBOUNCE_CYCLES - 1);

    logic [SYNC_STAGES-1:0] chain;
    logic [CW-1:0]          cnt;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst)
                    chain[i] <= 1'b0;
                else if (i == 0)
                    chain[i] <= level_async;
                else
                    chain[i] <= chain[(i > 0) ? i - 1 : 0];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt          <= '0;
            level_stable <= 1'b0;
        end else if (chain[SYNC_STAGES-1] == level_stable) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt          <= '0;
            level_stable <= chain[SYNC_STAGES-1];
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pmc_idle_watch.sv
module pmc_idle_watch #(
    parameter int CYCLES_PER_MS = 12000,
    parameter int IDLE_MS       = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic attached,
    input  logic frame_start,
    output logic idle
);
    localparam int LIMIT = CYCLES_PER_MS * IDLE_MS;
    localparam int CW    = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] gap;

    always_ff @(posedge clk) begin
        if (rst || !attached || frame_start)
            gap <= '0;
        else if (gap != LIM)
            gap <= gap + 1'b1;
    end

    assign idle = (gap == LIM);
endmodule

// File: rtl/pmc_key_router.sv
module pmc_key_router
    import pmc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      alone,
    input  key_t      keys,
    output key_t      to_report,
    output core_key_t to_core
);
    always_ff @(posedge clk) begin
        if (rst) begin
            to_report <= '0;
            to_core   <= '0;
        end else begin
            to_report <= report_route(keys, alone);
            to_core   <= core_route(keys, alone);
        end
    end
endmodule

// File: rtl/pmc_audio_mode_ctrl.sv
module pmc_audio_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int CYCLES_PER_MS   = 12000,
    parameter int IDLE_MS         = 3,
    parameter int DEBOUNCE_CYCLES = 1024,
    parameter int SYNC_STAGES     = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_attached,
    input  logic       host_suspend_req,
    input  logic       aux_present_n,
    input  logic       frame_start,
    input  logic [3:0] key_in,
    output logic       suspend,
    output logic       aux_select,
    output logic       standalone,
    output logic       sof_pulse,
    output logic [3:0] report_keys,
    output logic [2:0] core_keys
);
    logic      aux_active;
    logic      bus_idle;
    key_t      rep_k;
    core_key_t core_k;

    pmc_sync_debounce #(
        .SYNC_STAGES    (SYNC_STAGES),
        .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
    ) u_aux (
        .clk         (clk),
        .rst         (rst),
        .level_async (~aux_present_n),
        .level_stable(aux_active)
    );

    pmc_idle_watch #(
        .CYCLES_PER_MS(CYCLES_PER_MS),
        .IDLE_MS      (IDLE_MS)
    ) u_idle (
        .clk        (clk),
        .rst        (rst),
        .attached   (bus_attached),
        .frame_start(frame_start),
        .idle       (bus_idle)
    );

    pmc_key_router u_keys (
        .clk      (clk),
        .rst      (rst),
        .alone    (standalone),
        .keys     (key_t'(key_in)),
        .to_report(rep_k),
        .to_core  (core_k)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            suspend    <= 1'b0;
            aux_select <= 1'b0;
            standalone <= ~bus_attached;
            sof_pulse  <= 1'b0;
        end else begin
            suspend    <= lowpower_cause(host_suspend_req, bus_attached, bus_idle)
                          & ~aux_active;
            aux_select <= aux_active;
            standalone <= ~bus_attached | aux_active;
            sof_pulse  <= frame_start & bus_attached;
        end
    end

    assign report_keys = rep_k;
    assign core_keys   = core_k;
endmodule

// File: rtl/pmc_audio_mode_chk.sv
module pmc_audio_mode_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_attached,
    input logic       host_suspend_req,
    input logic       frame_start,
    input logic [3:0] key_in,
    input logic       suspend,
    input logic       aux_select,
    input logic       standalone,
    input logic       sof_pulse,
    input logic [3:0] report_keys,
    input logic [2:0] core_keys
);
    a_r3_aux_blocks_suspend: assert property (@(posedge clk) disable iff (rst)
        aux_select |-> !suspend);

    a_r1_detach_suspends: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!bus_attached) && !aux_select) |-> suspend);

    a_r2_request_suspends: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(host_suspend_req) && !aux_select) |-> suspend);

    a_r5_sof_echo: assert property (@(posedge clk) disable iff (rst)
        (frame_start && bus_attached) |=> sof_pulse);

    a_r5_sof_only_on_event: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> !sof_pulse);

    a_r7_report_silent: assert property (@(posedge clk) disable iff (rst)
        standalone |=> (report_keys == 4'b0000));

    a_r7_volup_to_core: assert property (@(posedge clk) disable iff (rst)
        (standalone && key_in[0]) |=> core_keys[0]);

    a_r9_core_silent: assert property (@(posedge clk) disable iff (rst)
        !standalone |=> (core_keys == 3'b000));
endmodule

bind pmc_audio_mode_ctrl pmc_audio_mode_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .bus_attached    (bus_attached),
    .host_suspend_req(host_suspend_req),
    .frame_start     (frame_start),
    .key_in          (key_in),
    .suspend         (suspend),
    .aux_select      (aux_select),
    .standalone      (standalone),
    .sof_pulse       (sof_pulse),
    .report_keys     (report_keys),
    .core_keys       (core_keys)
);

// File: tb/tb_pmc_audio_mode_ctrl.sv
`timescale 1ns/1ps
module tb_pmc_audio_mode_ctrl;
    localparam int CPM   = 40;
    localparam int IMS   = 3;
    localparam int DEB   = 16;
    localparam int LIMIT = CPM * IMS;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_attached = 1'b1;
    logic       host_suspend_req = 1'b0;
    logic       aux_present_n = 1'b1;
    logic       frame_start = 1'b0;
    logic [3:0] key_in = 4'b0;
    logic       suspend, aux_select, standalone, sof_pulse;
    logic [3:0] report_keys;
    logic [2:0] core_keys;

    int errors = 0;
    int checks = 0;
    int ph = 0;
    bit sof_auto = 1'b0;
    bit sof_man  = 1'b0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    pmc_audio_mode_ctrl #(
        .CYCLES_PER_MS  (CPM),
        .IDLE_MS        (IMS),
        .DEBOUNCE_CYCLES(DEB),
        .SYNC_STAGES    (2)
    ) dut (
        .clk(clk), .rst(rst), .bus_attached(bus_attached),
        .host_suspend_req(host_suspend_req), .aux_present_n(aux_present_n),
        .frame_start(frame_start), .key_in(key_in), .suspend(suspend),
        .aux_select(aux_select), .standalone(standalone), .sof_pulse(sof_pulse),
        .report_keys(report_keys), .core_keys(core_keys)
    );

    function automatic logic [3:0] exp_report(input logic [3:0] k, input logic alone);
        return alone ? 4'b0 : k;
    endfunction

    function automatic logic [2:0] exp_core(input logic [3:0] k, input logic alone);
        return alone ? k[2:0] : 3'b0;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // apply current stimulus variables at a falling edge
    task automatic step();
        @(negedge clk);
        frame_start = sof_man | (sof_auto && (ph % 20 == 0));
        ph++;
    endtask

    // step, then sample just after the following rising edge
    task automatic step_look();
        step();
        @(posedge clk);
        #1;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #1500000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        // R10: reset state, attached
        run(3);
        #1;
        chk("R10 suspend", suspend, 0);
        chk("R10 aux_select", aux_select, 0);
        chk("R10 sof_pulse", sof_pulse, 0);
        chk("R10 standalone attached", standalone, 0);
        bus_attached = 1'b0;
        run(2);
        #1;
        chk("R10 standalone detached", standalone, 1);
        bus_attached = 1'b1;
        run(2);
        rst = 1'b0;

        // R2: normal running, attached with frame starts
        sof_auto = 1'b1;
        run(30);
        #1;
        chk("R2 normal power", suspend, 0);
        sof_auto = 1'b0;
        run(2);
        // R5: single strobe
        sof_man = 1'b1;
        step_look();
        chk("R5 strobe high", sof_pulse, 1);
        sof_man = 1'b0;
        step_look();
        chk("R5 strobe single", sof_pulse, 0);
        // R9: attached key routing incl. bass
        key_in = 4'b1101;
        step_look();
        chk("R9 report", report_keys, 4'b1101);
        chk("R9 core silent", core_keys, 0);
        key_in = 4'b0;
        sof_man = 1'b1;
        step();
        sof_man = 1'b0;
        // R2: host request
        host_suspend_req = 1'b1;
        step_look();
        chk("R2 request", suspend, 1);
        host_suspend_req = 1'b0;
        step_look();
        chk("R2 release", suspend, 0);

        // R1 / R7 / R8 detached
        bus_attached = 1'b0;
        step_look();
        chk("R1 detach suspend", suspend, 1);
        chk("R7 standalone", standalone, 1);
        sof_man = 1'b1;
        step_look();
        chk("R5 no strobe detached", sof_pulse, 0);
        sof_man = 1'b0;
        key_in = 4'b0001;
        step_look();
        chk("R7 core vol up", core_keys, 3'b001);
        chk("R7 report silent", report_keys, 0);
        key_in = 4'b1000;
        step_look();
        chk("R8 bass core", core_keys, 0);
        chk("R8 bass report", report_keys, 0);
        key_in = 4'b0;

        // R3: auxiliary present vetoes suspend while detached + request
        host_suspend_req = 1'b1;
        aux_present_n = 1'b0;
        run(DEB - 4);
        #1;
        chk("R3 not yet selected", aux_select, 0);
        run(10);
        #1;
        chk("R3 aux select", aux_select, 1);
        chk("R3 veto", suspend, 0);
        chk("R7 standalone aux", standalone, 1);
        // R4: short glitch ignored
        aux_present_n = 1'b1;
        run(DEB / 2);
        aux_present_n = 1'b0;
        run(DEB + 4);
        #1;
        chk("R4 glitch ignored", aux_select, 1);
        chk("R4 still vetoed", suspend, 0);
        // attached with aux: still standalone, keys to core
        bus_attached = 1'b1;
        host_suspend_req = 1'b0;
        run(2);
        key_in = 4'b0110;
        step_look();
        chk("R7 aux core keys", core_keys, 3'b110);
        key_in = 4'b0;
        // remove aux source, then detach
        aux_present_n = 1'b1;
        run(DEB + 6);
        #1;
        chk("R3 aux released", aux_select, 0);
        bus_attached = 1'b0;
        step_look();
        chk("R1 suspend after aux removed", suspend, 1);

        // R6: idle timeout
        bus_attached = 1'b1;
        sof_auto = 1'b1;
        ph = 0;
        run(60);
        #1;
        chk("R6 traffic no suspend", suspend, 0);
        sof_auto = 1'b0;
        run(LIMIT - 30);
        #1;
        chk("R6 before limit", suspend, 0);
        run(40);
        #1;
        chk("R6 idle suspend", suspend, 1);
        sof_man = 1'b1;
        step();
        sof_man = 1'b0;
        run(3);
        #1;
        chk("R6 cleared by frame", suspend, 0);

        // random segments
        for (int s = 0; s < 40; s++) begin
            logic att;
            logic req;
            att = 1'($urandom);
            req = (($urandom % 4) == 0);
            bus_attached = att;
            host_suspend_req = req;
            sof_man = 1'b1;
            run(3);
            for (int c = 0; c < 6; c++) begin
                logic [3:0] k;
                logic sf;
                k = 4'($urandom);
                sf = (($urandom % 3) == 0);
                key_in = k;
                sof_man = sf;
                step_look();
                chk("R9/R7 random report", report_keys, exp_report(k, !att));
                chk("R7 random core", core_keys, exp_core(k, !att));
                chk("R5 random strobe", sof_pulse, sf & att);
                chk("R1/R2 random suspend", suspend, req | !att);
            end
            key_in = 4'b0;
            sof_man = 1'b0;
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule